// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Line-Break Reporting

This block is a single receive channel of an asynchronous serial port. It samples the serial input on a 16x oversampling clock enable. It rebuilds each character in a programmable format: 5 to 8 data bits, then an optional extra bit, then one stop bit. The extra bit is a parity bit or, in nine-bit mode, an address/data flag. A completed character is presented on a parallel word together with its error flags and a one-cycle valid strobe.

The channel rejects glitches on the line that only look like start bits. It reports parity and framing errors with the character they belong to. When the downstream buffer cannot take a character, the channel reports an overrun. It recognises a line break, including one that begins partway through a character. A break produces a start-of-break pulse when it is recognised and an end-of-break pulse when the line goes back to mark.

Baud-rate generation, buffering, bus access and interrupt handling are outside this block. The surrounding logic supplies the 16x enable and a ready level from the downstream buffer.

Top module: `urx_rx`

## Requirements
- R1: After reset, and while the line stays at mark (high), every strobe and event output stays low.
- R2: Data bits arrive least significant first. The count is set by `cfg_len`: 00=5, 01=6, 10=7, 11=8 bits. Bits above the chosen length read as zero in `out_data`.
- R3: A falling edge starts a start-bit check at the middle of the bit, on sample 8 of 16. If the line is high there, the receiver goes back to idle and produces no output, and the next genuine character is still received.
- R4: `cfg_par` selects the parity check: 00 none, 01 even, 10 odd, 11 forced. In forced mode the parity bit must equal `cfg_force`. When the bit does not match, `out_par_err` is set with the character. With parity set to none and nine-bit mode off, no extra bit is expected.
- R5: When `cfg_nine` is 1, one extra bit follows the data bits and is reported on `out_addr`. Parity is not checked, and `out_par_err` stays 0. With `cfg_nine` at 0, `out_addr` reads 0.
- R6: A stop bit sampled low sets `out_frm_err` on the delivered character, unless the character is a break.
- R7: A character whose data bits, extra bit (when present) and stop bit are all low is a break. It is not delivered. Instead, `brk_start` pulses for one clock.
- R8: After a break, `brk_end` pulses exactly once when the line is seen high again. The receiver then accepts the next character normally.
- R9: Suppose a break begins in the middle of a character. That character is delivered with `out_frm_err` set and its bits received before the break. Then `brk_start` and later `brk_end` follow.
- R10: A character that completes while `sink_ready` is low is discarded. In that case `out_valid` stays low and `ovr_evt` pulses for one clock. The next character is delivered normally once `sink_ready` is high.
- R11: `out_valid`, `ovr_evt`, `brk_start` and `brk_end` are single-clock pulses. Each is raised on the clock after a cycle with `tick` high. At most one of `out_valid`, `ovr_evt` and `brk_start` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 16x oversampling enable, one clock wide |
| rxd | input | 1 | Serial input, mark is high |
| cfg_len | input | 2 | Data bit count minus five |
| cfg_par | input | 2 | Parity mode: none, even, odd, forced |
| cfg_force | input | 1 | Expected parity value in forced mode |
| cfg_nine | input | 1 | Nine-bit mode, extra bit is address flag |
| sink_ready | input | 1 | Downstream buffer can accept a character |
| out_valid | output | 1 | Character strobe |
| out_data | output | 8 | Received data bits |
| out_par_err | output | 1 | Parity mismatch for this character |
| out_frm_err | output | 1 | Stop bit was low |
| out_addr | output | 1 | Extra bit in nine-bit mode |
| ovr_evt | output | 1 | Character dropped because sink was not ready |
| brk_start | output | 1 | Break recognised |
| brk_end | output | 1 | Line returned to mark after a break |

## Verification
The hardest case to reach is a break that starts in the middle of a character. The receiver has to finish the broken character with a framing error, restart on the still-low line and recognise a whole all-zero frame, all from one uninterrupted low level. The bench sends a start bit and three ones, then holds the line low for many bit times before releasing it. It expects the partial character, then the start-of-break event, then the end-of-break event, in that order. Glitches shorter than half a bit are driven to reach the false-start path, each followed by a valid frame to show the receiver came back to idle.

// File: rtl/urx_pkg.sv
package urx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_EXTRA, ST_STOP, ST_BREAK
   } urx_state_e;

   typedef enum logic [1:0] {
      PAR_NONE  = 2'b00,
      PAR_EVEN  = 2'b01,
      PAR_ODD   = 2'b10,
      PAR_FORCE = 2'b11
   } urx_par_e;

   localparam int URX_DW      = 8;
   localparam int URX_LEN_MIN = 5;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '1;
            end else begin
               q[0] <= din;
               for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/urx_frame.sv
module urx_frame
   import urx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic [1:0]        cfg_len,
   input  logic              has_extra,
   input  logic              brk_hit,
   output logic [URX_DW-1:0] data_q,
   output logic              extra_q,
   output logic              done,
   output logic              brk_over
);
   localparam int CW = $clog2(OSR);
   localparam int IW = $clog2(URX_DW);
   localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OSR - 1);

   urx_state_e     state;
   logic [CW-1:0]  cnt;
   logic [IW-1:0]  idx;
   logic [IW-1:0]  last_idx;

   assign last_idx = IW'(cfg_len) + IW'(URX_LEN_MIN - 1);
   assign done     = tick && (state == ST_STOP) && (cnt == LAST);
   assign brk_over = tick && (state == ST_BREAK) && rx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         idx     <= '0;
         data_q  <= '0;
         extra_q <= 1'b0;
      end else if (tick) begin
         case (state)
            ST_IDLE: begin
               if (!rx) begin
                  state <= ST_START;
                  cnt   <= '0;
               end
            end
            ST_START: begin
               if (cnt == MID) begin
                  cnt <= '0;
                  if (rx) begin
                     state <= ST_IDLE;
                  end else begin
                     state   <= ST_DATA;
                     idx     <= '0;
                     data_q  <= '0;
                     extra_q <= 1'b0;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == LAST) begin
                  cnt         <= '0;
                  data_q[idx] <= rx;
                  if (idx == last_idx) state <= has_extra ? ST_EXTRA : ST_STOP;
                  else                 idx   <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_EXTRA: begin
               if (cnt == LAST) begin
                  cnt     <= '0;
                  extra_q <= rx;
                  state   <= ST_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (cnt == LAST) begin
                  cnt   <= '0;
                  state <= brk_hit ? ST_BREAK : ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_BREAK: begin
               if (rx) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/urx_eval.sv
module urx_eval
   import urx_pkg::*;
(
   input  logic [URX_DW-1:0] data,
   input  logic              extra,
   input  logic              stop,
   input  logic [1:0]        cfg_par,
   input  logic              cfg_force,
   input  logic              cfg_nine,
   output logic              par_err,
   output logic              frm_err,
   output logic              brk,
   output logic              addr
);
   logic     ones_odd;
   urx_par_e mode;

   assign mode     = urx_par_e'(cfg_par);
   assign ones_odd = (^data) ^ extra;

   always_comb begin
      par_err = 1'b0;
      if (!cfg_nine) begin
         case (mode)
            PAR_EVEN:  par_err = ones_odd;
            PAR_ODD:   par_err = !ones_odd;
            PAR_FORCE: par_err = (extra != cfg_force);
            default:   par_err = 1'b0;
         endcase
      end
   end

   assign frm_err = !stop;
   assign brk     = (data == '0) && !extra && !stop;
   assign addr    = cfg_nine & extra;
endmodule

// File: rtl/urx_rx.sv
module urx_rx
   import urx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic [1:0] cfg_len,
   input  logic [1:0] cfg_par,
   input  logic       cfg_force,
   input  logic       cfg_nine,
   input  logic       sink_ready,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic       out_par_err,
   output logic       out_frm_err,
   output logic       out_addr,
   output logic       ovr_evt,
   output logic       brk_start,
   output logic       brk_end
);
   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("urx_rx: OSR must be even and at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("urx_rx: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic              rx_s;
   logic [URX_DW-1:0] f_data;
   logic              f_extra, f_done, f_brk_over;
   logic              e_par, e_frm, e_brk, e_addr;
   logic              has_extra;

   assign has_extra = cfg_nine || (cfg_par != PAR_NONE);

   urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
   );

   urx_frame #(.OSR(OSR)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
      .cfg_len(cfg_len), .has_extra(has_extra), .brk_hit(e_brk),
      .data_q(f_data), .extra_q(f_extra), .done(f_done), .brk_over(f_brk_over)
   );

   urx_eval u_eval (
      .data(f_data), .extra(f_extra), .stop(rx_s),
      .cfg_par(cfg_par), .cfg_force(cfg_force), .cfg_nine(cfg_nine),
      .par_err(e_par), .frm_err(e_frm), .brk(e_brk), .addr(e_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_par_err <= 1'b0;
         out_frm_err <= 1'b0;
         out_addr    <= 1'b0;
         ovr_evt     <= 1'b0;
         brk_start   <= 1'b0;
         brk_end     <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         ovr_evt   <= 1'b0;
         brk_start <= 1'b0;
         brk_end   <= f_brk_over;
         if (f_done) begin
            if (e_brk) begin
               brk_start <= 1'b1;
            end else if (sink_ready) begin
               out_valid   <= 1'b1;
               out_data    <= f_data;
               out_par_err <= e_par;
               out_frm_err <= e_frm;
               out_addr    <= e_addr;
            end else begin
               ovr_evt <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/urx_rx_chk.sv
module urx_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic sink_ready,
   input logic out_valid,
   input logic ovr_evt,
   input logic brk_start,
   input logic brk_end
);
   logic in_brk;

   always_ff @(posedge clk) begin
      if (!rst_n)         in_brk <= 1'b0;
      else if (brk_start) in_brk <= 1'b1;
      else if (brk_end)   in_brk <= 1'b0;
   end

   p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   p_event_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || ovr_evt || brk_start || brk_end) |-> $past(tick));
   p_one_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_valid, ovr_evt, brk_start}));
   p_valid_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(sink_ready));
   p_ovr_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |-> !$past(sink_ready));
   p_brk_start_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_start |-> !in_brk);
   p_brk_end_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_end |-> in_brk);
   p_no_char_in_brk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_brk |-> !out_valid && !ovr_evt);
endmodule

bind urx_rx urx_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .sink_ready(sink_ready),
   .out_valid(out_valid), .ovr_evt(ovr_evt),
   .brk_start(brk_start), .brk_end(brk_end)
);

// File: tb/sim_urx_rx.sv
module sim_urx_rx;
   localparam int TDIV = 4;
   localparam int BT   = 16 * TDIV;

   localparam int K_CHAR = 0;
   localparam int K_OVR  = 1;
   localparam int K_BRKS = 2;
   localparam int K_BRKE = 3;

   typedef struct {
      int         kind;
      logic [7:0] data;
      logic       pe;
      logic       fe;
      logic       ad;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_len = 2'b11;
   logic [1:0] cfg_par = 2'b00;
   logic       cfg_force = 1'b0;
   logic       cfg_nine = 1'b0;
   logic       sink_ready = 1'b1;
   logic       out_valid, out_par_err, out_frm_err, out_addr;
   logic       ovr_evt, brk_start, brk_end;
   logic [7:0] out_data;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];
   logic prev_valid = 1'b0;
   bit   done_flag = 1'b0;

   always #5 clk = ~clk;

   urx_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_force(cfg_force),
      .cfg_nine(cfg_nine), .sink_ready(sink_ready),
      .out_valid(out_valid), .out_data(out_data), .out_par_err(out_par_err),
      .out_frm_err(out_frm_err), .out_addr(out_addr), .ovr_evt(ovr_evt),
      .brk_start(brk_start), .brk_end(brk_end)
   );

   initial begin
      int c = 0;
      forever begin
         @(negedge clk);
         tick <= (c == TDIV - 1);
         c = (c == TDIV - 1) ? 0 : c + 1;
      end
   end

   task automatic push(input int kind, input logic [7:0] d, input logic pe,
                       input logic fe, input logic ad, input string req);
      exp_t e;
      e.kind = kind; e.data = d; e.pe = pe; e.fe = fe; e.ad = ad; e.req = req;
      q.push_back(e);
   endtask

   task automatic seen(input int kind);
      exp_t e;
      checks++;
      if (q.size() == 0) begin
         errors++;
         $display("FAIL R1: unexpected event kind=%0d, expected none", kind);
         return;
      end
      e = q.pop_front();
      if (kind != e.kind ||
          (kind == K_CHAR && (out_data != e.data || out_par_err != e.pe ||
                              out_frm_err != e.fe || out_addr != e.ad))) begin
         errors++;
         $display("FAIL %s: got kind=%0d data=%h pe=%b fe=%b ad=%b, expected kind=%0d data=%h pe=%b fe=%b ad=%b",
                  e.req, kind, out_data, out_par_err, out_frm_err, out_addr,
                  e.kind, e.data, e.pe, e.fe, e.ad);
      end
   endtask

   // Every clock: compare outputs against the expectation queue
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         if (out_valid && prev_valid) begin
            checks++; errors++;
            $display("FAIL R11: out_valid high two clocks, got 1 expected 0");
         end
         if (out_valid) seen(K_CHAR);
         if (ovr_evt)   seen(K_OVR);
         if (brk_start) seen(K_BRKS);
         if (brk_end)   seen(K_BRKE);
      end
      prev_valid = out_valid;
   end

   task automatic bit_time(input logic v, input int n);
      rxd = v;
      repeat (n * BT) @(negedge clk);
   endtask

   // Builds expected result from the requirements and sends one frame
   task automatic frame(input logic [7:0] d, input logic ext, input logic stp, input string req);
      int         len = int'(cfg_len) + 5;
      logic [7:0] m = d & 8'((1 << len) - 1);
      logic       has_ext = cfg_nine || (cfg_par != 2'b00);
      logic       e = has_ext ? ext : 1'b0;
      logic       pe = 1'b0;
      if (!cfg_nine) begin
         case (cfg_par)
            2'b01: pe = (^m) ^ e;
            2'b10: pe = !((^m) ^ e);
            2'b11: pe = (e != cfg_force);
            default: pe = 1'b0;
         endcase
      end
      if (m == 8'h00 && !e && !stp) begin
         push(K_BRKS, 8'h00, 1'b0, 1'b0, 1'b0, req);
         push(K_BRKE, 8'h00, 1'b0, 1'b0, 1'b0, req);
      end else if (!sink_ready) begin
         push(K_OVR, 8'h00, 1'b0, 1'b0, 1'b0, req);
      end else begin
         push(K_CHAR, m, pe, !stp, cfg_nine & e, req);
      end
      bit_time(1'b0, 1);
      for (int i = 0; i < len; i++) bit_time(d[i], 1);
      if (has_ext) bit_time(ext, 1);
      bit_time(stp, 1);
      bit_time(1'b1, 3);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      checks++;
      if (out_valid || ovr_evt || brk_start || brk_end) begin
         errors++;
         $display("FAIL R1: strobes during reset got %b%b%b%b expected 0000",
                  out_valid, ovr_evt, brk_start, brk_end);
      end
      rst_n = 1'b1;
      bit_time(1'b1, 4);

      // R2 formats, least significant bit first
      cfg_len = 2'b11; frame(8'hA5, 1'b0, 1'b1, "R2");
      cfg_len = 2'b00; frame(8'hF3, 1'b0, 1'b1, "R2");
      cfg_len = 2'b01; frame(8'h2A, 1'b0, 1'b1, "R2");
      cfg_len = 2'b10; frame(8'h5B, 1'b0, 1'b1, "R2");

      // R4 parity modes, good and bad
      cfg_len = 2'b11; cfg_par = 2'b01;
      frame(8'hA5, 1'b0, 1'b1, "R4");
      frame(8'hA5, 1'b1, 1'b1, "R4");
      cfg_len = 2'b10; cfg_par = 2'b10;
      frame(8'h15, 1'b0, 1'b1, "R4");
      frame(8'h15, 1'b1, 1'b1, "R4");
      cfg_par = 2'b11; cfg_force = 1'b1;
      frame(8'h33, 1'b1, 1'b1, "R4");
      frame(8'h33, 1'b0, 1'b1, "R4");

      // R5 nine-bit mode, parity ignored
      cfg_len = 2'b11; cfg_nine = 1'b1; cfg_par = 2'b01;
      frame(8'h81, 1'b1, 1'b1, "R5");
      frame(8'h81, 1'b0, 1'b1, "R5");
      cfg_nine = 1'b0; cfg_par = 2'b00;

      // R6 framing error
      frame(8'h3C, 1'b0, 1'b0, "R6");

      // R3 false starts, then a real frame
      rxd = 1'b0; repeat (BT / 4) @(negedge clk);
      bit_time(1'b1, 2);
      rxd = 1'b0; repeat (BT / 3) @(negedge clk);
      bit_time(1'b1, 2);
      frame(8'h69, 1'b0, 1'b1, "R3");

      // R10 overrun then recovery
      sink_ready = 1'b0; frame(8'h77, 1'b0, 1'b1, "R10");
      sink_ready = 1'b1; frame(8'h12, 1'b0, 1'b1, "R10");

      // R7 R8 full break, parity mode on
      cfg_par = 2'b01;
      push(K_BRKS, 8'h00, 1'b0, 1'b0, 1'b0, "R7");
      push(K_BRKE, 8'h00, 1'b0, 1'b0, 1'b0, "R8");
      bit_time(1'b0, 20);
      bit_time(1'b1, 3);
      frame(8'h5A, 1'b0, 1'b1, "R8");
      cfg_par = 2'b00;

      // R9 break starting inside a character
      push(K_CHAR, 8'h07, 1'b0, 1'b1, 1'b0, "R9");
      push(K_BRKS, 8'h00, 1'b0, 1'b0, 1'b0, "R9");
      push(K_BRKE, 8'h00, 1'b0, 1'b0, 1'b0, "R9");
      bit_time(1'b0, 1);
      bit_time(1'b1, 3);
      bit_time(1'b0, 24);
      bit_time(1'b1, 4);
      frame(8'hC3, 1'b0, 1'b1, "R9");

      bit_time(1'b1, 2);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL %s: %0d expected events missing, expected 0", q[0].req, q.size());
      end
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         checks++; errors++;
         $display("FAIL R1: watchdog expired, got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule